// File: doc/BRIEF.md
# Control Register Access Checker and Merge Unit

This unit sits between an instruction decoder and the core's control register file. For each request it takes a 12-bit register address, the current privilege level, a two-bit operation code (read, write, set, clear) and an operand. In the same cycle it decides whether the access is allowed. It also forms the merged value that would be written back and returns the register's prior contents.

The unit holds the floating-point exception flags and rounding mode itself. It answers the identity registers from constants and from a hart number input. Every other register lives in an external bank: the bank reports through `bank_hit` whether a register exists at the address, supplies its contents on `bank_rdata`, and takes `bank_we` and `bank_wdata`. Access rules that depend on the address (minimum privilege, read-only space, counter enable bits, floating-point unit on or off) are all evaluated here. When an access is refused, only a flag is raised. Trap delivery is left to the core.

Top module: `csr_access_unit`

## Requirements
- R1: Address bits [9:8] hold the lowest privilege allowed to touch the register, with user=0, supervisor=1 and machine=3. A request made at a lower `priv` value is flagged illegal.
- R2: An address whose bits [11:10] are both 1 is read-only. A request there is illegal if its effective mask is nonzero, and legal if the mask is zero (for example, a set with operand 0).
- R3: Operation codes are 0=read (mask 0), 1=write (mask all ones, new=operand), 2=set (new all ones, mask=operand) and 3=clear (new 0, mask=operand). The value written is (old & ~mask) | (new & mask).
- R4: A write reaches the target only for a valid, legal request with a nonzero mask. A legal request always returns the register's old value on `rd_data`, including when it writes. An illegal or idle request returns 0.
- R5: An address that is neither served locally nor reported by `bank_hit` is illegal.
- R6: Counter addresses are 0xC00–0xC1F and 0xC80–0xC9F. Below machine level, an access needs bit addr[4:0] of `mcnt_en`. At user level, the same bit of `scnt_en` is also needed.
- R7: Addresses 0x001 (flags), 0x002 (rounding mode) and 0x003 (combined) are illegal while `fs_state` is 0, unless `dbg_access` is high.
- R8: A committed write to any of the three floating-point addresses pulses `fs_dirty` in that cycle.
- R9: The flags register holds 5 bits and the rounding mode holds 3 bits. The combined register reads {rounding mode, flags} in bits [7:0], with zeros above. A write to it takes the rounding mode from bits [7:5] and the flags from bits [4:0].
- R10: Addresses 0xF11, 0xF12 and 0xF13 read as zero. Address 0xF14 reads `hart_id`.
- R11: `illegal` and `rd_data` depend combinationally on the request. Local state changes at the next rising clock edge, and nothing changes while `req_valid` is low. Reset clears the flags and the rounding mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 12 | Register address |
| req_op | input | 2 | 0 read, 1 write, 2 set, 3 clear |
| req_operand | input | XLEN | Source operand |
| priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| dbg_access | input | 1 | Request comes from the debugger |
| fs_state | input | 2 | Floating-point status field, 0 means off |
| mcnt_en | input | 32 | Machine-level counter enable bits |
| scnt_en | input | 32 | Supervisor-level counter enable bits |
| hart_id | input | XLEN | Hart number |
| bank_hit | input | 1 | External bank implements `req_addr` |
| bank_rdata | input | XLEN | External bank contents at `req_addr` |
| bank_we | output | 1 | External bank write strobe |
| bank_wdata | output | XLEN | Merged value for the bank |
| rd_data | output | XLEN | Old register value |
| illegal | output | 1 | Request refused |
| fs_dirty | output | 1 | Request to mark floating-point state dirty |

## Verification
The merge is driven with all four operations on both local and bank registers. The operands have overlapping and disjoint bit patterns, so a swapped mask and new value, or a dropped inversion, yields a distinct wrong word. Counter requests walk the privilege levels against enable words with a single cleared bit. This separates the machine-level gate from the supervisor-level gate, and shows that machine level ignores both. The floating-point addresses are hit with the unit off, on and clean, and from the debugger. Read-only space is hit with a real write and with a zero-mask set.

// File: rtl/csr_access_unit.sv
module csr_access_unit #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [11:0]     req_addr,
  input  logic [1:0]      req_op,
  input  logic [XLEN-1:0] req_operand,
  input  logic [1:0]      priv,
  input  logic            dbg_access,
  input  logic [1:0]      fs_state,
  input  logic [31:0]     mcnt_en,
  input  logic [31:0]     scnt_en,
  input  logic [XLEN-1:0] hart_id,
  input  logic            bank_hit,
  input  logic [XLEN-1:0] bank_rdata,
  output logic            bank_we,
  output logic [XLEN-1:0] bank_wdata,
  output logic [XLEN-1:0] rd_data,
  output logic            illegal,
  output logic            fs_dirty
);
  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_SET = 2'd2, OP_CLR = 2'd3;
  localparam logic [1:0] LVL_U = 2'd0, LVL_S = 2'd1, LVL_M = 2'd3;
  localparam logic [11:0] A_FLAGS = 12'h001, A_RMODE = 12'h002, A_FPALL = 12'h003;
  localparam logic [11:0] A_VEND = 12'hF11, A_ARCH = 12'hF12, A_IMPL = 12'hF13, A_HART = 12'hF14;
  localparam int FLW = 5;
  localparam int RMW = 3;
  localparam int PADW = XLEN - FLW - RMW;

  logic [FLW-1:0]  flags_q;
  logic [RMW-1:0]  rmode_q;
  logic [XLEN-1:0] mask, newv, old, merged;

  always_comb begin
    unique case (req_op)
      OP_WR:   begin mask = '1;          newv = req_operand; end
      OP_SET:  begin mask = req_operand; newv = '1;          end
      OP_CLR:  begin mask = req_operand; newv = '0;          end
      default: begin mask = '0;          newv = '0;          end
    endcase
  end

  wire is_flags = req_addr == A_FLAGS;
  wire is_rmode = req_addr == A_RMODE;
  wire is_fpall = req_addr == A_FPALL;
  wire is_fp    = is_flags | is_rmode | is_fpall;
  wire is_id    = req_addr == A_VEND | req_addr == A_ARCH | req_addr == A_IMPL | req_addr == A_HART;
  wire is_local = is_fp | is_id;
  wire is_ctr   = req_addr[11:5] == 7'h60 || req_addr[11:5] == 7'h64;

  wire [4:0] cbit  = req_addr[4:0];
  wire ctr_ok  = (priv >= LVL_M) || (mcnt_en[cbit] && ((priv >= LVL_S) || scnt_en[cbit]));
  wire lvl_ok  = priv >= req_addr[9:8];
  wire ro_ok   = !((req_addr[11:10] == 2'b11) && (|mask));
  wire fs_ok   = !is_fp || dbg_access || (fs_state != 2'b00);
  wire exists  = is_local || bank_hit;
  wire legal   = exists && lvl_ok && ro_ok && fs_ok && (!is_ctr || ctr_ok);

  always_comb begin
    old = bank_rdata;
    if (is_flags)      old = {{(XLEN-FLW){1'b0}}, flags_q};
    else if (is_rmode) old = {{(XLEN-RMW){1'b0}}, rmode_q};
    else if (is_fpall) old = {{PADW{1'b0}}, rmode_q, flags_q};
    else if (req_addr == A_HART) old = hart_id;
    else if (is_id)    old = '0;
  end

  assign merged = (old & ~mask) | (newv & mask);

  wire commit = req_valid && legal && (|mask);

  assign illegal    = req_valid && !legal;
  assign rd_data    = (req_valid && legal) ? old : '0;
  assign bank_we    = commit && !is_local;
  assign bank_wdata = merged;
  assign fs_dirty   = commit && is_fp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      rmode_q <= '0;
    end else if (commit) begin
      if (is_flags) flags_q <= merged[FLW-1:0];
      if (is_rmode) rmode_q <= merged[RMW-1:0];
      if (is_fpall) begin
        flags_q <= merged[FLW-1:0];
        rmode_q <= merged[FLW+RMW-1:FLW];
      end
    end
  end

  assert_low_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && priv < req_addr[9:8]) |-> illegal);

  assert_ro_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[11:10] == 2'b11 && req_op == OP_WR) |-> illegal);

  assert_read_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_op == OP_RD || illegal) |-> (!bank_we && !fs_dirty));

  assert_fp_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[11:2] == 10'd0 && req_addr[1:0] != 2'b00 && fs_state == 2'b00 && !dbg_access) |-> illegal);

  assert_user_ctr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[11:5] == 7'h60 && priv == LVL_U && !scnt_en[req_addr[4:0]]) |-> illegal);

  assert_rmode_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !illegal && req_addr == A_RMODE && req_op == OP_WR) |=> rmode_q == $past(req_operand[RMW-1:0]));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(flags_q) && $stable(rmode_q)));

  assert_dirty_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fs_dirty |-> (req_addr[11:2] == 10'd0 && !illegal && req_op != OP_RD));
endmodule

// File: tb/sim_csr_access_unit.sv
`timescale 1ns/1ps
module sim_csr_access_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_op = '0;
  logic [31:0] req_operand = '0;
  logic [1:0]  priv = 2'd3;
  logic        dbg_access = 1'b0;
  logic [1:0]  fs_state = 2'd3;
  logic [31:0] mcnt_en = '1;
  logic [31:0] scnt_en = '1;
  logic [31:0] hart_id = 32'd7;
  logic        bank_hit;
  logic [31:0] bank_rdata;
  logic        bank_we;
  logic [31:0] bank_wdata;
  logic [31:0] rd_data;
  logic        illegal;
  logic        fs_dirty;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  csr_access_unit #(.XLEN(32)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_op(req_op), .req_operand(req_operand), .priv(priv),
    .dbg_access(dbg_access), .fs_state(fs_state), .mcnt_en(mcnt_en),
    .scnt_en(scnt_en), .hart_id(hart_id), .bank_hit(bank_hit),
    .bank_rdata(bank_rdata), .bank_we(bank_we), .bank_wdata(bank_wdata),
    .rd_data(rd_data), .illegal(illegal), .fs_dirty(fs_dirty));

  logic [31:0] scratch;
  always_comb begin
    bank_hit = 1'b1;
    unique case (req_addr)
      12'h340: bank_rdata = scratch;
      12'hC00: bank_rdata = 32'h0000_1000;
      12'hC02: bank_rdata = 32'h0000_2000;
      12'hC03: bank_rdata = 32'h0000_3003;
      default: begin bank_rdata = '0; bank_hit = 1'b0; end
    endcase
  end
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) scratch <= '0;
    else if (bank_we && req_addr == 12'h340) scratch <= bank_wdata;

  task automatic check(input int rq, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [3:0]  rq;
    logic [1:0]  pv;
    logic        dbg;
    logic [1:0]  fs;
    logic [11:0] addr;
    logic [1:0]  op;
    logic [31:0] opnd;
    logic [31:0] men;
    logic [31:0] sen;
    logic        ill;
    logic [31:0] rd;
    logic        dirty;
  } vec_t;

  localparam int NV = 30;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;
  localparam vec_t TBL [NV] = '{
    '{4'd11, 2'd3, 1'b0, 2'd3, 12'h003, 2'd0, 32'h0,         ONES, ONES, 1'b0, 32'h0,         1'b0}, // R11 reset value
    '{4'd3,  2'd3, 1'b0, 2'd3, 12'h002, 2'd1, 32'hFFFF_FFF5, ONES, ONES, 1'b0, 32'h0,         1'b1}, // R3 write
    '{4'd9,  2'd3, 1'b0, 2'd3, 12'h003, 2'd0, 32'h0,         ONES, ONES, 1'b0, 32'h0000_00A0, 1'b0}, // R9 layout
    '{4'd3,  2'd0, 1'b0, 2'd3, 12'h001, 2'd2, 32'h13,        ONES, ONES, 1'b0, 32'h0,         1'b1}, // R3 set
    '{4'd3,  2'd0, 1'b0, 2'd3, 12'h003, 2'd3, 32'h21,        ONES, ONES, 1'b0, 32'h0000_00B3, 1'b1}, // R3 clear
    '{4'd9,  2'd0, 1'b0, 2'd3, 12'h003, 2'd0, 32'h0,         ONES, ONES, 1'b0, 32'h0000_0092, 1'b0}, // R9
    '{4'd7,  2'd0, 1'b0, 2'd0, 12'h001, 2'd1, 32'h1F,        ONES, ONES, 1'b1, 32'h0,         1'b0}, // R7 off
    '{4'd7,  2'd0, 1'b1, 2'd0, 12'h002, 2'd0, 32'h0,         ONES, ONES, 1'b0, 32'h4,         1'b0}, // R7 debugger
    '{4'd8,  2'd0, 1'b1, 2'd0, 12'h002, 2'd1, 32'h1,         ONES, ONES, 1'b0, 32'h4,         1'b1}, // R8
    '{4'd9,  2'd0, 1'b0, 2'd3, 12'h003, 2'd0, 32'h0,         ONES, ONES, 1'b0, 32'h0000_0032, 1'b0}, // R9
    '{4'd4,  2'd3, 1'b0, 2'd3, 12'h340, 2'd1, 32'hDEAD_BEEF, ONES, ONES, 1'b0, 32'h0,         1'b0}, // R4
    '{4'd1,  2'd1, 1'b0, 2'd3, 12'h340, 2'd0, 32'h0,         ONES, ONES, 1'b1, 32'h0,         1'b0}, // R1
    '{4'd3,  2'd3, 1'b0, 2'd3, 12'h340, 2'd2, 32'h10,        ONES, ONES, 1'b0, 32'hDEAD_BEEF, 1'b0}, // R3
    '{4'd3,  2'd3, 1'b0, 2'd3, 12'h340, 2'd3, 32'hFFFF_0000, ONES, ONES, 1'b0, 32'hDEAD_BEFF, 1'b0}, // R3
    '{4'd4,  2'd3, 1'b0, 2'd3, 12'h340, 2'd0, 32'h0,         ONES, ONES, 1'b0, 32'h0000_BEFF, 1'b0}, // R4
    '{4'd2,  2'd3, 1'b0, 2'd3, 12'hC00, 2'd1, 32'h5,         ONES, ONES, 1'b1, 32'h0,         1'b0}, // R2
    '{4'd2,  2'd3, 1'b0, 2'd3, 12'hC00, 2'd2, 32'h0,         ONES, ONES, 1'b0, 32'h0000_1000, 1'b0}, // R2 zero mask
    '{4'd6,  2'd0, 1'b0, 2'd3, 12'hC00, 2'd0, 32'h0,         ONES, ONES, 1'b0, 32'h0000_1000, 1'b0}, // R6
    '{4'd6,  2'd0, 1'b0, 2'd3, 12'hC02, 2'd0, 32'h0,  32'hFFFF_FFFB, ONES, 1'b1, 32'h0,   1'b0}, // R6
    '{4'd6,  2'd1, 1'b0, 2'd3, 12'hC02, 2'd0, 32'h0,  32'hFFFF_FFFB, ONES, 1'b1, 32'h0,   1'b0}, // R6
    '{4'd6,  2'd1, 1'b0, 2'd3, 12'hC02, 2'd0, 32'h0,  ONES, 32'hFFFF_FFFB, 1'b0, 32'h2000, 1'b0}, // R6
    '{4'd6,  2'd0, 1'b0, 2'd3, 12'hC02, 2'd0, 32'h0,  ONES, 32'hFFFF_FFFB, 1'b1, 32'h0,   1'b0}, // R6
    '{4'd6,  2'd3, 1'b0, 2'd3, 12'hC02, 2'd0, 32'h0,  32'h0, 32'h0,        1'b0, 32'h2000, 1'b0}, // R6
    '{4'd6,  2'd0, 1'b0, 2'd3, 12'hC03, 2'd0, 32'h0,  32'h8, 32'h8,        1'b0, 32'h3003, 1'b0}, // R6
    '{4'd10, 2'd3, 1'b0, 2'd3, 12'hF11, 2'd0, 32'h0,         ONES, ONES, 1'b0, 32'h0,         1'b0}, // R10
    '{4'd10, 2'd3, 1'b0, 2'd3, 12'hF14, 2'd0, 32'h0,         ONES, ONES, 1'b0, 32'h7,         1'b0}, // R10
    '{4'd5,  2'd3, 1'b0, 2'd3, 12'h7FF, 2'd0, 32'h0,         ONES, ONES, 1'b1, 32'h0,         1'b0}, // R5
    '{4'd1,  2'd0, 1'b0, 2'd3, 12'hF14, 2'd0, 32'h0,         ONES, ONES, 1'b1, 32'h0,         1'b0}, // R1
    '{4'd2,  2'd3, 1'b0, 2'd3, 12'hF14, 2'd1, 32'h9,         ONES, ONES, 1'b1, 32'h0,         1'b0}, // R2
    '{4'd7,  2'd0, 1'b0, 2'd1, 12'h001, 2'd0, 32'h0,         ONES, ONES, 1'b0, 32'h12,        1'b0}  // R7 clean
  };

  task automatic drive(input logic v, input logic [1:0] pv, input logic [11:0] a, input logic [1:0] op, input logic [31:0] d);
    @(negedge clk);
    req_valid = v; priv = pv; req_addr = a; req_op = op; req_operand = d;
    #1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      dbg_access = TBL[i].dbg; fs_state = TBL[i].fs;
      mcnt_en = TBL[i].men; scnt_en = TBL[i].sen;
      req_valid = 1'b1; priv = TBL[i].pv; req_addr = TBL[i].addr;
      req_op = TBL[i].op; req_operand = TBL[i].opnd;
      #1;
      check(int'(TBL[i].rq), {31'd0, illegal}, {31'd0, TBL[i].ill}, $sformatf("vec %0d illegal", i));
      check(int'(TBL[i].rq), rd_data, TBL[i].rd, $sformatf("vec %0d rd_data", i));
      check(int'(TBL[i].rq), {31'd0, fs_dirty}, {31'd0, TBL[i].dirty}, $sformatf("vec %0d fs_dirty", i));
    end
    dbg_access = 1'b0; fs_state = 2'd3; mcnt_en = '1; scnt_en = '1;

    // R4: bank strobe and merged data
    drive(1'b1, 2'd3, 12'h340, 2'd1, 32'h55);
    check(4, {31'd0, bank_we}, 32'd1, "bank_we on write");
    check(4, bank_wdata, 32'h55, "bank_wdata on write");
    drive(1'b1, 2'd3, 12'h340, 2'd2, 32'h0);
    check(4, {31'd0, bank_we}, 32'd0, "bank_we zero-mask set");
    check(4, rd_data, 32'h55, "old value after write");

    // R11: idle request changes nothing and returns nothing
    drive(1'b0, 2'd3, 12'h002, 2'd1, 32'h7);
    check(11, {31'd0, illegal}, 32'd0, "idle illegal");
    check(11, rd_data, 32'h0, "idle rd_data");
    drive(1'b1, 2'd3, 12'h002, 2'd0, 32'h0);
    check(11, rd_data, 32'h1, "rounding mode after idle");

    // R11: reset clears local state
    @(negedge clk); rst_n = 1'b0; req_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    drive(1'b1, 2'd3, 12'h003, 2'd0, 32'h0);
    check(11, rd_data, 32'h0, "combined after reset");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule